// File: doc/BRIEF.md
# Register Bank Write Guard with Key Release

This block sits on the write path of a 32-bit peripheral register bank. It decodes a simple synchronous register bus (address, write strobe, write data, read data) and tells the neighbouring register bank, through a write-permit output, whether a write to a protected register may land. Two guard registers control it. Writing either of them while the bank is open closes the bank, whatever the value. Once the bank is closed, every protected write is dropped.

The bank opens again only after a fixed two-word key exchange. The first key word goes to the upper guard register and arms a one-bit flag. The second key word then goes to the lower guard register and releases the lock, but only while that flag is armed. Any other write to a guard register while the bank is closed disarms the flag. Writes to non-guard registers do not disturb it.

Guard register writes are never blocked, so the release sequence always gets through. Reads are never blocked either. One example data register at byte offset 0x10 shows the gating: its writes are qualified by the same permit.

Top module: `lkg_write_guard`

## Requirements
- R1: After reset the bank is open. The lower guard register (byte offset 0x00) reads 0, the example data register (byte offset 0x10) reads 0, and wr_permit is 0 while no write is presented.
- R2: A write of any value to the lower guard register while open closes the bank. From the next cycle that register reads 1 (bit 0 = closed, other bits 0).
- R3: A write of any value to the upper guard register (byte offset 0x7C) while open also closes the bank.
- R4: While closed, a write to the data register leaves its value unchanged and wr_permit stays 0 during that write.
- R5: Writing 0xC0DE1248 to the upper guard register, then 0xC0DEFA73 to the lower guard register, opens the bank. Writes to other addresses between the two key words do not break the sequence. The lower guard register reads 0 afterwards.
- R6: While closed, the bank stays closed if the second key word arrives without the first, if the keys come in the wrong order or to the wrong registers, or if any other guard register write comes between the two key words.
- R7: wr_permit is 1 exactly during a write to a non-guard address while the bank is open. Guard register writes never raise it.
- R8: Reads are never blocked: the data register returns its value while the bank is closed.
- R9: A data register write presented in the cycle right after the releasing key write takes effect.
- R10: The upper guard register and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (7) | Byte address of the access |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| wr_permit | output | 1 | Write to a protected register allowed this cycle |

## Verification
The hardest state to reach from the ports is the armed flag, because nothing reads it back directly. Its effect only shows on the lower guard register after a second key word. The stimulus therefore drives several near-miss sequences and then reads the lock status each time: second key alone, a wrong word between the keys, keys swapped between registers, and a data write between the keys. Only the last of these may open the bank. The cycle right after a release is covered by presenting a data write back-to-back with the releasing key write.

// File: rtl/lkg_pkg.sv
package lkg_pkg;
    localparam int BUS_W = 32;

    localparam logic [BUS_W-1:0] KEY_FIRST  = 32'hC0DE1248;
    localparam logic [BUS_W-1:0] KEY_SECOND = 32'hC0DEFA73;

    typedef struct packed {
        logic closed;
        logic armed;
    } guard_state_t;
endpackage

// File: rtl/lkg_key_engine.sv
module lkg_key_engine
    import lkg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [BUS_W-1:0] wdata,
    output logic             closed,
    output logic             armed
);
    guard_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_lo) begin
            if (!st_q.closed) begin
                st_d.closed = 1'b1;
                st_d.armed  = 1'b0;
            end else if (st_q.armed && (wdata == KEY_SECOND)) begin
                st_d.closed = 1'b0;
                st_d.armed  = 1'b0;
            end else begin
                st_d.armed  = 1'b0;
            end
        end else if (wr_hi) begin
            if (!st_q.closed) begin
                st_d.closed = 1'b1;
                st_d.armed  = 1'b0;
            end else begin
                st_d.armed  = (wdata == KEY_FIRST);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign closed = st_q.closed;
    assign armed  = st_q.armed;

    // R2
    a_r2_close_on_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (!closed && wr_lo) |=> closed);
    // R3
    a_r3_close_on_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (!closed && wr_hi) |=> closed);
    // R6: release only follows an armed second-key write
    a_r6_release_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(closed) |-> $past(armed && wr_lo));
    // R6
    a_r6_arm_only_closed: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> closed);
endmodule

// File: rtl/lkg_data_reg.sv
module lkg_data_reg
    import lkg_pkg::*;
#(
    parameter logic [BUS_W-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] q
);
    logic [BUS_W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (wr_en) val_d = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) val_q <= RESET_VAL;
        else        val_q <= val_d;
    end

    assign q = val_q;
endmodule

// File: rtl/lkg_read_mux.sv
module lkg_read_mux
    import lkg_pkg::*;
(
    input  logic             sel_lo,
    input  logic             sel_data,
    input  logic             closed,
    input  logic [BUS_W-1:0] data_q,
    output logic [BUS_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (sel_lo)        rdata = {{(BUS_W-1){1'b0}}, closed};
        else if (sel_data) rdata = data_q;
    end
endmodule

// File: rtl/lkg_write_guard.sv
module lkg_write_guard
    import lkg_pkg::*;
#(
    parameter int               ADDR_W   = 7,
    parameter logic [ADDR_W-1:0] LO_OFS   = 7'h00,
    parameter logic [ADDR_W-1:0] HI_OFS   = 7'h7C,
    parameter logic [ADDR_W-1:0] DATA_OFS = 7'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              wr_permit
);
    logic hit_lo, hit_hi, hit_data;
    logic closed, armed;
    logic [BUS_W-1:0] data_q;

    assign hit_lo   = (bus_addr == LO_OFS);
    assign hit_hi   = (bus_addr == HI_OFS);
    assign hit_data = (bus_addr == DATA_OFS);

    assign wr_permit = bus_we && !closed && !hit_lo && !hit_hi;

    lkg_key_engine u_keys (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_lo  (bus_we && hit_lo),
        .wr_hi  (bus_we && hit_hi),
        .wdata  (bus_wdata),
        .closed (closed),
        .armed  (armed)
    );

    lkg_data_reg u_data (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_permit && hit_data),
        .wdata (bus_wdata),
        .q     (data_q)
    );

    lkg_read_mux u_rmux (
        .sel_lo   (hit_lo),
        .sel_data (hit_data),
        .closed   (closed),
        .data_q   (data_q),
        .rdata    (bus_rdata)
    );

    // R4
    a_r4_closed_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (closed && bus_we && hit_data) |=> $stable(data_q));
    // R7
    a_r7_no_permit_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_lo || hit_hi) |-> !wr_permit);
endmodule

// File: tb/tb_lkg_write_guard.sv
module tb_lkg_write_guard;
    localparam logic [6:0] A_LO   = 7'h00;
    localparam logic [6:0] A_HI   = 7'h7C;
    localparam logic [6:0] A_DATA = 7'h10;
    localparam logic [6:0] A_NONE = 7'h24;
    localparam logic [31:0] K1 = 32'hC0DE1248;
    localparam logic [31:0] K2 = 32'hC0DEFA73;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wr_permit;

    int applied = 0;
    int miscomp = 0;
    bit done = 0;

    logic [31:0] exp_rd_q[$];
    bit          chk_rd_q[$];
    bit          exp_pm_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    lkg_write_guard dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wr_permit(wr_permit)
    );

    task automatic op(input bit we, input logic [6:0] a, input logic [31:0] wd,
                      input bit chk, input logic [31:0] erd, input bit epm,
                      input string tag);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = wd;
        exp_rd_q.push_back(erd); chk_rd_q.push_back(chk);
        exp_pm_q.push_back(epm); tag_q.push_back(tag);
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] wd, input bit epm,
                      input string tag);
        op(1'b1, a, wd, 1'b0, 32'h0, epm, tag);
    endtask

    task automatic rd(input logic [6:0] a, input logic [31:0] erd, input string tag);
        op(1'b0, a, 32'h0, 1'b1, erd, 1'b0, tag);
    endtask

    // monitor: compare mid low phase, away from the rising edge
    always begin
        @(negedge clk);
        #2;
        if (exp_pm_q.size() != 0) begin
            logic [31:0] erd;
            bit ck, epm;
            string tg;
            erd = exp_rd_q.pop_front(); ck = chk_rd_q.pop_front();
            epm = exp_pm_q.pop_front(); tg = tag_q.pop_front();
            applied++;
            if (wr_permit !== epm || (ck && bus_rdata !== erd)) begin
                miscomp++;
                $display("FAIL %s: rdata=%h permit=%b expected rdata=%h permit=%b",
                         tg, bus_rdata, wr_permit, ck ? erd : bus_rdata, epm);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            miscomp++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(A_LO,   32'h0, "R1 lo guard after reset");
        rd(A_DATA, 32'h0, "R1 data after reset");
        rd(A_HI,   32'h0, "R10 hi guard reads zero");
        rd(A_NONE, 32'h0, "R10 unmapped reads zero");
        // R7 open write permitted
        wr(A_DATA, 32'h98765432, 1'b1, "R7 permit on open data write");
        rd(A_DATA, 32'h98765432, "R7 data written while open");
        // R2 close via lower guard
        wr(A_LO, 32'h0, 1'b0, "R7 no permit on guard write");
        rd(A_LO, 32'h1, "R2 closed after lo write");
        // R4 dropped write, R8 read while closed
        wr(A_DATA, 32'hA9876543, 1'b0, "R4 no permit while closed");
        rd(A_DATA, 32'h98765432, "R4 R8 data held and readable");
        // R6 second key alone
        wr(A_LO, K2, 1'b0, "R6 key2 alone");
        rd(A_LO, 32'h1, "R6 still closed after key2 alone");
        // R6 wrong word between keys
        wr(A_HI, K1, 1'b0, "R6 key1");
        wr(A_LO, 32'h00001234, 1'b0, "R6 wrong word");
        wr(A_LO, K2, 1'b0, "R6 key2 after disarm");
        rd(A_LO, 32'h1, "R6 still closed after interrupted keys");
        // R6 swapped registers
        wr(A_LO, K1, 1'b0, "R6 key1 to lo");
        wr(A_HI, K2, 1'b0, "R6 key2 to hi");
        rd(A_LO, 32'h1, "R6 still closed after swapped keys");
        // R5 release with data write between keys, R9 back-to-back write
        wr(A_HI, K1, 1'b0, "R5 key1");
        wr(A_DATA, 32'h00000055, 1'b0, "R4 data write between keys blocked");
        wr(A_LO, K2, 1'b0, "R5 key2");
        wr(A_DATA, 32'hA9876543, 1'b1, "R9 permit right after release");
        rd(A_DATA, 32'hA9876543, "R9 data took first write after release");
        rd(A_LO, 32'h0, "R5 open after key pair");
        // R3 close via upper guard
        wr(A_HI, 32'hFFFFFFFF, 1'b0, "R3 hi write");
        rd(A_LO, 32'h1, "R3 closed after hi write");
        rd(A_HI, 32'h0, "R10 hi guard reads zero while closed");
        wr(A_DATA, 32'h0, 1'b0, "R4 blocked after hi close");
        rd(A_DATA, 32'hA9876543, "R4 data held after hi close");
        // R5 repeated key1 then key2
        wr(A_HI, K1, 1'b0, "R5 key1 first");
        wr(A_HI, K1, 1'b0, "R5 key1 again");
        wr(A_LO, K2, 1'b0, "R5 key2");
        rd(A_LO, 32'h0, "R5 open after rearmed keys");
        wr(A_DATA, 32'h13572468, 1'b1, "R7 permit after reopen");
        rd(A_DATA, 32'h13572468, "R7 data after reopen");
        rd(A_NONE, 32'h0, "R10 unmapped reads zero at end");
        @(negedge clk);
        bus_we = 1'b0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
        $finish;
    end
endmodule